// File: doc/BRIEF.md
# Nibble Register Serial Master

This block drives a three-line serial link to an external clock chip whose registers are four bits wide. A host hands over one request at a time: a register address, a direction flag and, for writes, a data nibble. The block turns that request into command bytes on a clock line and a shared data line. For reads it also clocks in one response byte. It hands back the low nibble and signals completion. The data line is bidirectional. The block drives a data value and a separate output-enable for an external tri-state pad, and it samples the pad's input during a receive. The chip-enable line is left to the surrounding sequencer.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response is delivered, and `req_valid` has no effect while `req_ready` is low. The response side has no back-pressure. `rsp_valid` is a single-cycle pulse, and `rsp_rdata` must be captured in that cycle. It holds its value until the next response.

Every bit spends `HALF_CYC` system cycles with the clock high and the data settled, then `HALF_CYC` cycles with the clock low. The default of 70 cycles gives 700 ns per half at 100 MHz.

Top module: `nibble_serial_master`

## Requirements
- R1: After reset the serial clock is high, the data output-enable is low, `req_ready` is high and `rsp_valid` is low. Whenever `req_ready` is high the clock is high and the output-enable is low.
- R2: A command byte has bit 6 set for a read, bit 5 set for an address byte, bit 4 set for a data byte, and the nibble in bits 3:0. Bit 7 is zero. A write sends the address byte `0x20|addr` and then the data byte `0x10|wdata`.
- R3: A read sends the single byte `0x60|addr`. It then clocks in 8 bits with the output-enable low and returns bits 3:0 of the received byte on `rsp_rdata`.
- R4: Bytes go out and come in most-significant bit first, with exactly 8 clock pulses per byte.
- R5: For each bit, the data value is held with the clock high for `HALF_CYC` cycles. The clock is then low for exactly `HALF_CYC` cycles, and the data output does not change while the clock is low.
- R6: On a transmitted byte, the output-enable rises one cycle after the first bit is placed on the data output, while the clock is high. It falls on the cycle in which the clock returns high after the eighth bit. It is low at every clock fall of a received byte.
- R7: On a receive, the input is sampled on the last cycle of the clock-high part of each bit, just before the clock falls. A value present only while the clock is low has no effect.
- R8: `req_ready` drops on the edge after a request is taken and stays low until the response. A `req_valid` raised while `req_ready` is low starts no transfer.
- R9: `rsp_valid` is high for exactly one cycle, `32*HALF_CYC+2` cycles after the accepting edge, for both reads and writes.
- R10: After a write, `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_rw | input | 1 | 1 = read, 0 = write |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write nibble |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 4 | Read nibble (zero after a write) |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Data value toward the pad |
| sdo_oe | output | 1 | Pad output-enable |
| sdi_i | input | 1 | Data value from the pad |

## Verification
The assertions watch the line discipline on every cycle. They check idle levels while ready, data held steady through each clock-low half, and the output-enable edges relative to the data and clock. They also check the single-cycle response pulse and that `req_ready` drops after acceptance. Only the bench scenarios can show byte contents and bit order, exact low-half lengths, and which sample point feeds the returned nibble. The bench's serial device drives a deliberately wrong value during each clock-low half to expose a wrong sample point. The scenarios also cover the exact response latency and that a request offered while busy leaves the bus untouched.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;
  localparam int RD_BIT = 6;
  localparam int AD_BIT = 5;
  localparam int DT_BIT = 4;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_LOW} eng_st_t;
  typedef enum logic [1:0] {C_IDLE, C_HEAD, C_TAIL} ctl_st_t;

  function automatic logic [BYTE_W-1:0] addr_byte(input logic rd, input logic [NIB_W-1:0] a);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = a;
    b[AD_BIT] = 1'b1;
    b[RD_BIT] = rd;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] data_byte(input logic [NIB_W-1:0] d);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = d;
    b[DT_BIT] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/nsm_half_timer.sv
module nsm_half_timer #(
  parameter int HALF_CYC = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clr)      cnt <= '0;
    else if (run)      cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/nsm_byte_engine.sv
module nsm_byte_engine
  import nsm_pkg::*;
#(
  parameter int HALF_CYC = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rx_mode,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              sdi,
  output logic              sclk,
  output logic              sdo,
  output logic              oe,
  output logic              done,
  output logic [NIB_W-1:0]  rx_low
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST_BIT = BW'(BYTE_W - 1);

  eng_st_t           st;
  logic [BYTE_W-1:0] shreg;
  logic [BW-1:0]     bidx;
  logic              rxm;
  logic              tick;

  nsm_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (go),
    .run  (st != E_IDLE),
    .tick (tick)
  );

  assign rx_low = shreg[NIB_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= E_IDLE;
      shreg <= '0;
      bidx  <= '0;
      rxm   <= 1'b0;
      sclk  <= 1'b1;
      sdo   <= 1'b0;
      oe    <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        E_IDLE: if (go) begin
          st    <= E_SETUP;
          bidx  <= '0;
          rxm   <= rx_mode;
          shreg <= rx_mode ? '0 : tx_byte;
          sdo   <= rx_mode ? 1'b0 : tx_byte[BYTE_W-1];
        end
        E_SETUP: begin
          if (!rxm) oe <= 1'b1;
          if (tick) begin
            st   <= E_LOW;
            sclk <= 1'b0;
            if (rxm) shreg <= {shreg[BYTE_W-2:0], sdi};
          end
        end
        E_LOW: if (tick) begin
          sclk <= 1'b1;
          if (bidx == LAST_BIT) begin
            st   <= E_IDLE;
            done <= 1'b1;
            oe   <= 1'b0;
          end else begin
            st   <= E_SETUP;
            bidx <= bidx + 1'b1;
            if (!rxm) begin
              shreg <= {shreg[BYTE_W-2:0], 1'b0};
              sdo   <= shreg[BYTE_W-2];
            end
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nibble_serial_master.sv
module nibble_serial_master
  import nsm_pkg::*;
#(
  parameter int HALF_CYC = 70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_rw,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [NIB_W-1:0] rsp_rdata,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             sdo_oe,
  input  logic             sdi_i
);
  ctl_st_t           st;
  logic              rw_q;
  logic [NIB_W-1:0]  wd_q;
  logic              accept;
  logic              eng_go;
  logic              eng_rx;
  logic              eng_done;
  logic [BYTE_W-1:0] eng_byte;
  logic [NIB_W-1:0]  eng_rx_low;

  assign req_ready = (st == C_IDLE);
  assign accept    = req_valid && req_ready;
  assign eng_go    = accept || ((st == C_HEAD) && eng_done);
  assign eng_rx    = (st == C_HEAD) && rw_q;
  assign eng_byte  = accept ? addr_byte(req_rw, req_addr) : data_byte(wd_q);

  nsm_byte_engine #(.HALF_CYC(HALF_CYC)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (eng_go),
    .rx_mode(eng_rx),
    .tx_byte(eng_byte),
    .sdi    (sdi_i),
    .sclk   (sclk_o),
    .sdo    (sdo_o),
    .oe     (sdo_oe),
    .done   (eng_done),
    .rx_low (eng_rx_low)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= C_IDLE;
      rw_q      <= 1'b0;
      wd_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        C_IDLE: if (accept) begin
          st   <= C_HEAD;
          rw_q <= req_rw;
          wd_q <= req_wdata;
        end
        C_HEAD: if (eng_done) st <= C_TAIL;
        C_TAIL: if (eng_done) begin
          st        <= C_IDLE;
          rsp_valid <= 1'b1;
          rsp_rdata <= rw_q ? eng_rx_low : '0;
        end
        default: st <= C_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nsm_checker.sv
module nsm_checker (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic sclk_o,
  input logic sdo_o,
  input logic sdo_oe
);
  a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sclk_o && !sdo_oe));

  a_r5_data_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_o && $past(!sclk_o)) |-> $stable(sdo_o));

  a_r6_oe_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> (sclk_o && $stable(sdo_o)));

  a_r6_oe_off_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_oe) |-> $rose(sclk_o));

  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r9_ready_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);
endmodule

bind nibble_serial_master nsm_checker u_nsm_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .sclk_o   (sclk_o),
  .sdo_o    (sdo_o),
  .sdo_oe   (sdo_oe)
);

// File: tb/nibble_serial_master_tb.sv
module nibble_serial_master_tb_top;
  localparam int H = 70;
  localparam int LAT = 32 * H + 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rw = 1'b0;
  logic [3:0] req_addr = '0;
  logic [3:0] req_wdata = '0;
  logic       rsp_valid;
  logic [3:0] rsp_rdata;
  logic       sclk_o, sdo_o, sdo_oe;
  logic       sdi_i = 1'b0;

  nibble_serial_master #(.HALF_CYC(H)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_rw(req_rw), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sclk_o(sclk_o), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_head(input logic rd, input logic [3:0] a);
    return {1'b0, rd, 1'b1, 1'b0, a};
  endfunction

  function automatic logic [7:0] exp_data(input logic [3:0] d);
    return {4'b0001, d};
  endfunction

  // serial device model and monitors
  logic [7:0] cap [256];
  int         ncap = 0;
  int         nrsp = 0;
  int         hs_cyc = 0;
  int         rsp_cyc = 0;
  logic [3:0] last_rdata = '0;
  logic [7:0] resp_byte = '0;
  logic       prev_sclk = 1'b1;
  int         low_cnt = 0;
  int         txn_bits = 0;
  logic [7:0] txb = '0;
  bit         rxm = 1'b0;
  int         rxidx = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (req_valid && req_ready) hs_cyc = cyc;
      if (rsp_valid) begin
        nrsp++;
        rsp_cyc = cyc;
        last_rdata = rsp_rdata;
      end
      if (prev_sclk && !sclk_o) begin
        low_cnt = 0;
        if (rxm) begin
          chk(sdo_oe == 1'b0, "R6 oe low during receive", sdo_oe, 0);
          rxidx++;
        end else begin
          chk(sdo_oe == 1'b1, "R6 oe high during transmit", sdo_oe, 1);
          txb = {txb[6:0], sdo_o};
          txn_bits++;
          if (txn_bits == 8) begin
            cap[ncap % 256] = txb;
            ncap++;
            txn_bits = 0;
            if (txb[6]) begin
              rxm = 1'b1;
              rxidx = 0;
            end
          end
        end
      end
      if (!prev_sclk && sclk_o) begin
        chk(low_cnt == H, "R5 clock low length", low_cnt, H);
        if (rxm && rxidx == 8) rxm = 1'b0;
      end
      if (!sclk_o) low_cnt++;
      if (rxm && rxidx < 8) begin
        if (sclk_o) sdi_i = resp_byte[7 - rxidx];
        else if (rxidx == 0) sdi_i = 1'b0;
        else sdi_i = ~resp_byte[8 - rxidx];
      end else if (rxm && !sclk_o) begin
        sdi_i = ~resp_byte[0];
      end else begin
        sdi_i = 1'b0;
      end
      prev_sclk = sclk_o;
    end
  end

  task automatic run_txn(input logic rw, input logic [3:0] a, input logic [3:0] d,
                         input logic [7:0] resp, input bit inject);
    int base_cap, base_rsp;
    base_cap = ncap;
    base_rsp = nrsp;
    resp_byte = resp;
    @(posedge clk); #2;
    req_valid = 1'b1; req_rw = rw; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    req_valid = 1'b0;
    req_addr = ~a; req_wdata = ~d; req_rw = ~rw;
    if (inject) begin
      repeat (5 * H) @(posedge clk);
      #2 req_valid = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
      @(posedge clk); #2 req_valid = 1'b0;
    end
    for (int k = 0; k < 40 * H + 100 && nrsp == base_rsp; k++) @(negedge clk);
    repeat (4 * H) @(negedge clk);
    chk(nrsp - base_rsp == 1, "R9 one response pulse", nrsp - base_rsp, 1);
    chk(rsp_cyc - hs_cyc == LAT, "R9 response latency", rsp_cyc - hs_cyc, LAT);
    chk(req_ready == 1'b1, "R8 ready after response", req_ready, 1);
    chk(cap[base_cap % 256] == exp_head(rw, a), rw ? "R3 read head byte" : "R2 write head byte",
        cap[base_cap % 256], exp_head(rw, a));
    if (rw) begin
      chk(ncap - base_cap == 1, "R3 single byte sent on read", ncap - base_cap, 1);
      chk(last_rdata == resp[3:0], "R3 R7 returned nibble", last_rdata, resp[3:0]);
    end else begin
      chk(ncap - base_cap == 2, "R4 two bytes on write", ncap - base_cap, 2);
      chk(cap[(base_cap + 1) % 256] == exp_data(d), "R2 write data byte",
          cap[(base_cap + 1) % 256], exp_data(d));
      chk(last_rdata == 4'h0, "R10 rdata zero after write", last_rdata, 0);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0A1F));
    repeat (5) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_o == 1'b1, "R1 clock idles high", sclk_o, 1);
    chk(sdo_oe == 1'b0, "R1 oe off after reset", sdo_oe, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);

    run_txn(1'b0, 4'h0, 4'h0, 8'h00, 1'b0);
    run_txn(1'b0, 4'hF, 4'hF, 8'h00, 1'b1);
    run_txn(1'b1, 4'hF, 4'h0, 8'hFF, 1'b0);
    run_txn(1'b1, 4'h0, 4'h0, 8'hA5, 1'b1);
    run_txn(1'b1, 4'h7, 4'h0, 8'h5A, 1'b0);
    run_txn(1'b0, 4'hE, 4'h4, 8'h00, 1'b0);
    run_txn(1'b1, 4'h3, 4'h0, 8'h00, 1'b0);

    for (int i = 0; i < 18; i++) begin
      logic rw;
      logic [3:0] a, d;
      logic [7:0] r;
      rw = 1'($urandom);
      a  = 4'($urandom);
      d  = 4'($urandom);
      r  = 8'($urandom);
      run_txn(rw, a, d, r, (i % 4) == 0);
    end
    finish_run();
  end
endmodule